// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block decides when a small microcontroller core may run. It watches a power-on reset, an asynchronous active-low reset pin, a watchdog time-out pulse, a HALT request from the core and a set of interrupt request lines. After every reset and after every wake-up from HALT, it holds the core still for a fixed oscillator settling window. It tells the core what kind of restart to perform: a full (cold) reset, a partial (warm) reset of only the program counter and stack pointer, or a plain resume. It also keeps two status flags that let software tell afterwards which event caused the restart.

The settling window is timed by a free counter that is cleared on entry to the window. When the counter reaches its last value, a single-cycle `ready` strobe fires and `run_en` rises in the same cycle. For a wake-up caused by an interrupt, a companion strobe `isr_go` shows whether the core should enter the interrupt routine or simply continue with the next instruction. An interrupt line that was already requesting when HALT was entered is masked for the whole HALT period.

Top module: `rst_wake_seq`

## Requirements
- R1: While `rst` is high and after it falls, `cold_rst`=1 and `run_en`=0 and both status flags read 0 (`to_flag`=0, `pdf_flag`=0). The `ready` strobe follows exactly 1024 clock edges after the last edge on which `rst` was high.
- R2: Every settling window lasts exactly STARTUP_CYC (1024) clock edges, counted from the edge that starts it. `ready` is high for exactly one cycle, in the cycle in which `run_en` rises, and `cold_rst`/`warm_rst` fall in that same cycle.
- R3: `ext_rst_n` is active low and passes through a 2-flop synchroniser, so it acts on the third clock edge after it changes. While it is held low the window is restarted on every edge, and `ready` follows 1026 edges after the pin is released.
- R4: When the reset pin is asserted while running, the block does a cold reset and leaves both status flags unchanged.
- R5: When the reset pin is asserted while halted, the block does a cold reset and sets `to_flag`=0, `pdf_flag`=1.
- R6: A watchdog time-out while running gives a cold reset, sets `to_flag`=1 and leaves `pdf_flag` unchanged.
- R7: A watchdog time-out while halted gives a warm reset (`warm_rst`=1, `cold_rst`=0) and sets `to_flag`=1, `pdf_flag`=1.
- R8: A HALT request while running drops `run_en` and sets `pdf_flag`=1, `to_flag`=0. A watchdog-clear pulse while running sets both flags to 0.
- R9: While halted, a rise on an interrupt line that was low on the HALT entry edge starts a wake-up window with neither reset output asserted. A line that was high on the HALT entry edge never wakes the block during that HALT.
- R10: At the end of an interrupt wake-up window, `isr_go` pulses together with `ready` only if one of the waking lines had its enable set and `stack_full` was 0 on the wake edge. Otherwise `isr_go` stays 0.
- R11: When events coincide on one edge while halted, the reset pin wins over a watchdog time-out, and a watchdog time-out wins over an interrupt.
- R12: During a settling window, `wdt_tmo`, `halt_req`, `wdt_clr` and interrupt lines have no effect on the flags, the reset kind or the window length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | Asynchronous active-low reset pin |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| halt_req | input | 1 | HALT instruction executed by the core |
| wdt_clr | input | 1 | Watchdog-clear instruction executed by the core |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| stack_full | input | 1 | Core call stack has no free entry |
| cold_rst | output | 1 | Full core reset, held for the window |
| warm_rst | output | 1 | Program counter and stack pointer reset, held for the window |
| run_en | output | 1 | Core may execute |
| ready | output | 1 | One-cycle strobe at the end of a settling window |
| isr_go | output | 1 | One-cycle strobe with `ready`: enter the interrupt routine |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
On every cycle, the assertions check that the reset outputs and `run_en` are mutually exclusive, that `run_en` only rises together with `ready`, that `isr_go` never appears without `ready`, and that the settling counter advances by one or is cleared. They also check that the flags take their encoded values after HALT entry and after a warm reset. The exact 1024- and 1026-edge window lengths, the masking of lines that were pending at HALT entry, the unchanged-flag cases, the priority on coinciding events and the interrupt-versus-resume decision can only be shown by the bench's directed scenarios, which measure the cycles at the ports.

// File: rtl/rwseq_pkg.sv
package rwseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    K_COLD = 2'd0,
    K_WARM = 2'd1,
    K_WAKE = 2'd2
  } settle_kind_e;
endpackage

// File: rtl/rwseq_sync.sv
module rwseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pin_n_s
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= {sr_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_n_s = sr_q[STAGES-1];
endmodule

// File: rtl/rwseq_timer.sv
module rwseq_timer #(
  parameter int STARTUP_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done = en && !clr && (cnt_q == LAST);

  // R2: the window counter only steps by one or restarts from zero
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r2_count_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/rwseq_irq_arm.sv
module rwseq_irq_arm #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [N_IRQ-1:0] req,
  output logic [N_IRQ-1:0] hit
);
  logic [N_IRQ-1:0] armed_q;

  // a line requesting on the HALT entry edge stays disarmed for that HALT
  always_ff @(posedge clk) begin
    if (rst)          armed_q <= '0;
    else if (capture) armed_q <= ~req;
  end

  assign hit = req & armed_q;
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq
  import rwseq_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int STARTUP_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_n,
  input  logic             wdt_tmo,
  input  logic             halt_req,
  input  logic             wdt_clr,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             stack_full,
  output logic             cold_rst,
  output logic             warm_rst,
  output logic             run_en,
  output logic             ready,
  output logic             isr_go,
  output logic             to_flag,
  output logic             pdf_flag
);
  seq_st_e      state_q;
  settle_kind_e kind_q;
  logic         to_q, pdf_q, ready_q, isr_go_q, isr_pend_q;
  logic         ext_n_s, ext_act;
  logic         tmr_clr, tmr_en, tmr_done;
  logic         arm_cap;
  logic [N_IRQ-1:0] irq_hit;

  rwseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(ext_rst_n), .pin_n_s(ext_n_s)
  );

  assign ext_act = !ext_n_s;
  assign tmr_en  = (state_q == ST_SETTLE);
  assign tmr_clr = (state_q != ST_SETTLE) || ext_act;

  rwseq_timer #(.STARTUP_CYC(STARTUP_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .done(tmr_done)
  );

  assign arm_cap = (state_q == ST_RUN) && halt_req && !ext_act && !wdt_tmo;

  rwseq_irq_arm #(.N_IRQ(N_IRQ)) u_arm (
    .clk(clk), .rst(rst), .capture(arm_cap), .req(irq_req), .hit(irq_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SETTLE;
      kind_q     <= K_COLD;
      to_q       <= 1'b0;
      pdf_q      <= 1'b0;
      ready_q    <= 1'b0;
      isr_go_q   <= 1'b0;
      isr_pend_q <= 1'b0;
    end else begin
      ready_q  <= 1'b0;
      isr_go_q <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (ext_act) begin
            state_q <= ST_SETTLE;
            kind_q  <= K_COLD;
          end else if (wdt_tmo) begin
            state_q <= ST_SETTLE;
            kind_q  <= K_COLD;
            to_q    <= 1'b1;
          end else if (halt_req) begin
            state_q <= ST_HALT;
            to_q    <= 1'b0;
            pdf_q   <= 1'b1;
          end else if (wdt_clr) begin
            to_q    <= 1'b0;
            pdf_q   <= 1'b0;
          end
        end
        ST_HALT: begin
          if (ext_act) begin
            state_q <= ST_SETTLE;
            kind_q  <= K_COLD;
            to_q    <= 1'b0;
            pdf_q   <= 1'b1;
          end else if (wdt_tmo) begin
            state_q <= ST_SETTLE;
            kind_q  <= K_WARM;
            to_q    <= 1'b1;
            pdf_q   <= 1'b1;
          end else if (|irq_hit) begin
            state_q    <= ST_SETTLE;
            kind_q     <= K_WAKE;
            isr_pend_q <= (|(irq_hit & irq_en)) && !stack_full;
          end
        end
        ST_SETTLE: begin
          if (ext_act) begin
            kind_q <= K_COLD;
          end else if (tmr_done) begin
            state_q  <= ST_RUN;
            ready_q  <= 1'b1;
            isr_go_q <= isr_pend_q && (kind_q == K_WAKE);
          end
        end
        default: state_q <= ST_SETTLE;
      endcase
    end
  end

  assign cold_rst = (state_q == ST_SETTLE) && (kind_q == K_COLD);
  assign warm_rst = (state_q == ST_SETTLE) && (kind_q == K_WARM);
  assign run_en   = (state_q == ST_RUN);
  assign ready    = ready_q;
  assign isr_go   = isr_go_q;
  assign to_flag  = to_q;
  assign pdf_flag = pdf_q;

  // R2: run resumes only through the end-of-window strobe
  a_r2_run_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |-> ready);
  a_r2_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R4: reset kinds and run are exclusive
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cold_rst, warm_rst, run_en}));
  // R7: warm reset always reports a halted watchdog time-out
  a_r7_warm_flags: assert property (@(posedge clk) disable iff (rst)
    $rose(warm_rst) |-> (to_flag && pdf_flag));
  // R8: HALT entry flag encoding
  a_r8_halt_flags: assert property (@(posedge clk) disable iff (rst)
    arm_cap |=> (pdf_flag && !to_flag && !run_en));
  // R10: interrupt entry only at the end of a window
  a_r10_isr_with_ready: assert property (@(posedge clk) disable iff (rst)
    isr_go |-> ready);
  // R12: inputs other than the reset pin do not shorten a window
  a_r12_settle_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE && !tmr_done) |=> (state_q == ST_SETTLE));
endmodule

// File: tb/rst_wake_seq_tb.sv
module rst_wake_seq_tb;
  localparam int N_IRQ = 4;

  logic clk = 1'b0;
  logic rst, ext_rst_n, wdt_tmo, halt_req, wdt_clr, stack_full;
  logic [N_IRQ-1:0] irq_req, irq_en;
  logic cold_rst, warm_rst, run_en, ready, isr_go, to_flag, pdf_flag;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rst_wake_seq #(.N_IRQ(N_IRQ), .STARTUP_CYC(1024), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_tmo(wdt_tmo),
    .halt_req(halt_req), .wdt_clr(wdt_clr), .irq_req(irq_req),
    .irq_en(irq_en), .stack_full(stack_full), .cold_rst(cold_rst),
    .warm_rst(warm_rst), .run_en(run_en), .ready(ready), .isr_go(isr_go),
    .to_flag(to_flag), .pdf_flag(pdf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic enter_halt();
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
  endtask

  task automatic t_power_up();
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 cold_rst in reset", int'(cold_rst), 1);
    check("R1 run_en in reset", int'(run_en), 0);
    check("R1 flags after power-up", int'({to_flag, pdf_flag}), 0);
    rst = 1'b0;
    wait_ready(n);
    check("R1 window after power-up", n, 1024);
    check("R2 run_en with ready", int'({run_en, cold_rst}), 2);
    @(negedge clk);
    check("R2 ready one cycle", int'(ready), 0);
  endtask

  task automatic t_halt_irq();
    int n;
    irq_en  = 4'b0011;
    irq_req = 4'b0001;
    @(negedge clk);
    enter_halt();
    check("R8 halt drops run_en", int'(run_en), 0);
    check("R8 halt flags", int'({to_flag, pdf_flag}), 1);
    repeat (5) @(negedge clk);
    check("R9 pending line does not wake", int'({run_en, cold_rst, warm_rst}), 0);
    irq_req = 4'b0000;
    @(negedge clk);
    irq_req = 4'b0010;
    @(negedge clk);
    irq_req = 4'b0000;
    check("R9 wake without reset", int'({cold_rst, warm_rst, run_en}), 0);
    wait_ready(n);
    check("R9 window after irq wake", n - 1, 1023);
    check("R10 isr_go enabled line", int'(isr_go), 1);
    check("R9 flags after irq wake", int'({to_flag, pdf_flag}), 1);
  endtask

  task automatic t_irq_resume(input logic [N_IRQ-1:0] line, input logic sfull, input string tag);
    int n;
    @(negedge clk);
    enter_halt();
    irq_req    = line;
    stack_full = sfull;
    @(negedge clk);
    irq_req    = '0;
    stack_full = 1'b0;
    wait_ready(n);
    check({tag, " window"}, n, 1024);
    check({tag, " isr_go"}, int'(isr_go), 0);
  endtask

  task automatic t_wdt_run();
    int n;
    @(negedge clk);
    wdt_tmo = 1'b1;
    @(negedge clk);
    wdt_tmo = 1'b0;
    check("R6 cold on watchdog in run", int'({cold_rst, warm_rst}), 2);
    check("R6 flags TO set PDF kept", int'({to_flag, pdf_flag}), 3);
    wait_ready(n);
    check("R2 window after watchdog", n, 1024);
  endtask

  task automatic t_ext_run();
    int n;
    @(negedge clk);
    ext_rst_n = 1'b0;
    @(negedge clk);
    check("R3 synchroniser delay", int'(run_en), 1);
    repeat (2) @(negedge clk);
    check("R4 cold on pin in run", int'(cold_rst), 1);
    check("R4 flags unchanged", int'({to_flag, pdf_flag}), 3);
    repeat (10) @(negedge clk);
    ext_rst_n = 1'b1;
    wait_ready(n);
    check("R3 window after pin release", n, 1026);
  endtask

  task automatic t_wdt_clr();
    @(negedge clk);
    wdt_clr = 1'b1;
    @(negedge clk);
    wdt_clr = 1'b0;
    check("R8 watchdog clear flags", int'({to_flag, pdf_flag}), 0);
  endtask

  task automatic t_wdt_halt();
    int n;
    @(negedge clk);
    enter_halt();
    wdt_tmo = 1'b1;
    @(negedge clk);
    wdt_tmo = 1'b0;
    check("R7 warm on watchdog in halt", int'({cold_rst, warm_rst}), 1);
    check("R7 flags", int'({to_flag, pdf_flag}), 3);
    repeat (100) @(negedge clk);
    wdt_tmo = 1'b1;
    irq_req = 4'b0010;
    @(negedge clk);
    wdt_tmo = 1'b0;
    irq_req = 4'b0000;
    halt_req = 1'b1;
    wdt_clr  = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    wdt_clr  = 1'b0;
    check("R12 kind kept in window", int'({cold_rst, warm_rst}), 1);
    check("R12 flags kept in window", int'({to_flag, pdf_flag}), 3);
    wait_ready(n);
    check("R12 window length kept", n, 922);
    check("R12 no isr after warm", int'(isr_go), 0);
  endtask

  task automatic t_ext_halt();
    int n;
    @(negedge clk);
    enter_halt();
    ext_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 cold on pin in halt", int'({cold_rst, warm_rst}), 2);
    check("R5 flags", int'({to_flag, pdf_flag}), 1);
    ext_rst_n = 1'b1;
    wait_ready(n);
    check("R3 window after pin in halt", n, 1026);
  endtask

  task automatic t_prio_pin_wdt();
    int n;
    @(negedge clk);
    wdt_clr = 1'b1;
    @(negedge clk);
    wdt_clr = 1'b0;
    enter_halt();
    ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    wdt_tmo = 1'b1;
    @(negedge clk);
    wdt_tmo = 1'b0;
    check("R11 pin beats watchdog kind", int'({cold_rst, warm_rst}), 2);
    check("R11 pin beats watchdog flags", int'({to_flag, pdf_flag}), 1);
    ext_rst_n = 1'b1;
    wait_ready(n);
    check("R11 window after pin", n, 1026);
  endtask

  task automatic t_prio_wdt_irq();
    int n;
    @(negedge clk);
    enter_halt();
    wdt_tmo = 1'b1;
    irq_req = 4'b0010;
    @(negedge clk);
    wdt_tmo = 1'b0;
    irq_req = 4'b0000;
    check("R11 watchdog beats irq", int'({cold_rst, warm_rst}), 1);
    wait_ready(n);
    check("R11 window", n, 1024);
    check("R11 no isr after watchdog", int'(isr_go), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ext_rst_n = 1'b1; wdt_tmo = 1'b0; halt_req = 1'b0;
    wdt_clr = 1'b0; stack_full = 1'b0; irq_req = '0; irq_en = '0;
    @(negedge clk);
    t_power_up();
    t_halt_irq();
    t_irq_resume(4'b0100, 1'b0, "R10 disabled line");
    t_irq_resume(4'b0010, 1'b1, "R10 stack full");
    t_wdt_run();
    t_ext_run();
    t_wdt_clr();
    t_wdt_halt();
    t_ext_halt();
    t_prio_pin_wdt();
    t_prio_wdt_irq();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule